// File: doc/BRIEF.md
# Multi-Lane Full-Duplex SPI Word Shifter

This block is the shift engine of an SPI master that moves one 16-bit character at a time over a selectable number of data lanes. Transmit lanes and receive lanes are separate buses of equal width, so both directions run together. One lane gives ordinary serial SPI. Two, four or eight lanes cut the word time to 8, 4 or 2 serial clocks.

The 16-bit shift register is split into equal slices, one slice for each active lane. On every rising serial-clock edge the whole register moves left by one position. Each outgoing lane is driven from the highest bit of its slice. Each incoming lane is loaded into the lowest bit of its slice. When the last bit period ends, the register is copied into a receive buffer and a sticky receive flag is raised.

Software writes a word to start a transfer, polls or takes an interrupt on the receive flag, and clears the flags with a single pulse. Writes made while a word is in flight are dropped and recorded in an error flag. A completion that arrives while the receive flag is still set is recorded in an overrun flag.

Top module: `pspi_engine`

## Requirements
- R1: After reset the block is idle, with `cs_n_o`=1, `sclk_o`=0, `simo_o`=0, `busy_o`=0, `rx_data_o`=0 and all three flags at 0.
- R2: A `tx_wr_i` pulse while idle starts a transfer. From the next cycle `busy_o`=1 and `cs_n_o`=0, and `sclk_o` stays low for the first half period.
- R3: `lane_mode_i` selects the lane count: 0 gives 1 lane, 1 gives 2, 2 gives 4 and 3 gives 8. The value is captured at the start write, and changes to it during a transfer have no effect.
- R4: The slice width is W = 16/N for N lanes. During bit period j (counting from 0, before the (j+1)-th rising edge), `simo_o[k]` carries transmit bit k*W+W-1-j, and lanes k ≥ N drive 0.
- R5: On each rising `sclk_o` edge, `somi_i[k]` is loaded into bit k*W of the register. The word received in bit period j on lane k therefore ends up in `rx_data_o[k*W+W-1-j]`.
- R6: A word takes exactly 16/N rising edges. On the falling edge after the last rising edge, `rx_data_o` is loaded, `rx_int_o` is set, `busy_o` drops and `cs_n_o` returns high.
- R7: Each high and low phase of `sclk_o` lasts HALF_DIV system clocks, and `sclk_o` is low whenever the block is idle.
- R8: A `tx_wr_i` pulse while busy does not change the word in flight. It sets `tx_err_o`.
- R9: `rx_int_o` stays set until it is cleared. A completion while `rx_int_o` is already 1 sets `rx_ovr_o`.
- R10: A `flag_clr_i` pulse clears all three flags. If the pulse falls in the same cycle as a completion, `rx_int_o` ends at 1 and `rx_ovr_o` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_wr_i | input | 1 | Write strobe for the transmit word |
| tx_data_i | input | 16 | Transmit word |
| lane_mode_i | input | 2 | Lane count select (0:1, 1:2, 2:4, 3:8) |
| flag_clr_i | input | 1 | Clears the receive, overrun and error flags |
| somi_i | input | 8 | Incoming data lanes |
| sclk_o | output | 1 | Serial clock, idles low |
| simo_o | output | 8 | Outgoing data lanes |
| cs_n_o | output | 1 | Chip select, active low, held for one word |
| busy_o | output | 1 | A word is in flight |
| rx_data_o | output | 16 | Receive buffer |
| rx_int_o | output | 1 | Sticky word-received flag |
| rx_ovr_o | output | 1 | Receive overrun flag |
| tx_err_o | output | 1 | Write-while-busy flag |

## Verification
The bench checks every outgoing lane in every bit period against a tap model, for all four lane counts. An engine that wired the taps to the bottom of each slice, or reversed the lane order, would send bits in the wrong order and fail those checks. It also assembles the expected receive word from random incoming lane values, which catches a design that loaded the wrong slice bit or stopped one beat early or late.

Directed words change `lane_mode_i` and pulse `tx_wr_i` in the middle of a transfer. A design that re-read the mode, or accepted the late write, would corrupt the data. The bench also times a clear into the completion cycle and lets completions stack up without a clear. These cases expose any wrong priority between setting and clearing `rx_int_o` and `rx_ovr_o`.

// File: rtl/pspi_pkg.sv
package pspi_pkg;

    // Character width and the widest lane group the engine supports
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned LANE_MAX  = 8;
    // One mode per power-of-two lane count from 1 up to LANE_MAX
    localparam int unsigned NMODES    = $clog2(LANE_MAX) + 1;
    localparam int unsigned MODE_W    = $clog2(NMODES);

    typedef enum logic [MODE_W-1:0] {
        LM_X1 = 2'd0,
        LM_X2 = 2'd1,
        LM_X4 = 2'd2,
        LM_X8 = 2'd3
    } lane_mode_e;

endpackage

// File: rtl/pspi_clkgen.sv
// Serial clock divider: produces sclk and one-cycle edge strobes while run_i is high.
module pspi_clkgen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } cg_state_t;

    cg_state_t cg_d, cg_q;
    logic      wrap;

    always_comb begin
        cg_d   = cg_q;
        wrap   = run_i && (cg_q.cnt == CW'(HALF_DIV - 1));
        rise_o = wrap && !cg_q.sclk;
        fall_o = wrap &&  cg_q.sclk;
        if (!run_i) begin
            cg_d.cnt  = '0;
            cg_d.sclk = 1'b0;
        end else if (wrap) begin
            cg_d.cnt  = '0;
            cg_d.sclk = !cg_q.sclk;
        end else begin
            cg_d.cnt  = cg_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cg_q <= '0;
        else         cg_q <= cg_d;
    end

    assign sclk_o = cg_q.sclk;

    // R7: once stopped, the serial clock parks low
    a_r7_park_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !sclk_o);

    // R7: the divider count never passes the half-period limit
    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cg_q.cnt < CW'(HALF_DIV));

endmodule

// File: rtl/pspi_lane_map.sv
// Lane tap selection and slice-wise shift for every supported lane count.
module pspi_lane_map
    import pspi_pkg::*;
#(
    parameter int unsigned W_WORD = WORD_W,
    parameter int unsigned W_LANE = LANE_MAX
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [W_WORD-1:0] shreg_i,
    input  logic [W_LANE-1:0] somi_i,
    output logic [W_LANE-1:0] taps_o,
    output logic [W_WORD-1:0] shifted_o
);
    localparam int unsigned NM = $clog2(W_LANE) + 1;

    logic [NM-1:0][W_LANE-1:0] tap_all;
    logic [NM-1:0][W_WORD-1:0] nxt_all;

    for (genvar m = 0; m < NM; m++) begin : g_mode
        localparam int unsigned NL = 1 << m;
        localparam int unsigned SW = W_WORD / NL;

        logic [W_LANE-1:0] tap_m;
        logic [W_WORD-1:0] nxt_m;

        always_comb begin
            tap_m = '0;
            nxt_m = {shreg_i[W_WORD-2:0], 1'b0};
            for (int k = 0; k < NL; k++) begin
                tap_m[k]      = shreg_i[k*SW + SW - 1];
                nxt_m[k*SW]   = somi_i[k];
            end
        end

        assign tap_all[m] = tap_m;
        assign nxt_all[m] = nxt_m;
    end

    always_comb begin
        taps_o    = tap_all[mode_i];
        shifted_o = nxt_all[mode_i];
    end

endmodule

// File: rtl/pspi_flags.sv
// Sticky receive, overrun and write-error flags.
module pspi_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic done_i,
    input  logic wr_busy_i,
    input  logic clr_i,
    output logic rx_int_o,
    output logic rx_ovr_o,
    output logic tx_err_o
);
    typedef struct packed {
        logic rx_int;
        logic rx_ovr;
        logic tx_err;
    } fl_state_t;

    fl_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_i) begin
            fl_d.rx_int = 1'b0;
            fl_d.rx_ovr = 1'b0;
            fl_d.tx_err = 1'b0;
        end
        if (done_i) begin
            if (fl_q.rx_int && !clr_i) fl_d.rx_ovr = 1'b1;
            fl_d.rx_int = 1'b1;
        end
        if (wr_busy_i) fl_d.tx_err = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign rx_int_o = fl_q.rx_int;
    assign rx_ovr_o = fl_q.rx_ovr;
    assign tx_err_o = fl_q.tx_err;

    // R9: overrun only appears when a word lands on an unread one
    a_r9_ovr_needs_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_ovr_o) |-> $past(rx_int_o) && $past(done_i));

    // R8: the error flag rises only after a write during a transfer
    a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_err_o) |-> $past(wr_busy_i));

    // R9: the receive flag holds unless a clear arrives
    a_r9_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_int_o && !clr_i |=> rx_int_o);

    // R10: a clear without completion leaves both receive flags low
    a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i && !done_i |=> !rx_int_o && !rx_ovr_o);

endmodule

// File: rtl/pspi_engine.sv
// Top: full-duplex multi-lane SPI master word shifter.
module pspi_engine
    import pspi_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned W_WORD   = WORD_W,
    parameter int unsigned W_LANE   = LANE_MAX
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_wr_i,
    input  logic [W_WORD-1:0] tx_data_i,
    input  logic [MODE_W-1:0] lane_mode_i,
    input  logic              flag_clr_i,
    input  logic [W_LANE-1:0] somi_i,
    output logic              sclk_o,
    output logic [W_LANE-1:0] simo_o,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic [W_WORD-1:0] rx_data_o,
    output logic              rx_int_o,
    output logic              rx_ovr_o,
    output logic              tx_err_o
);
    localparam int unsigned BW = $clog2(W_WORD + 1);

    typedef struct packed {
        logic              busy;
        logic [MODE_W-1:0] mode;
        logic [W_WORD-1:0] shreg;
        logic [BW-1:0]     beats;
        logic [W_WORD-1:0] rxbuf;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic              rise, fall;
    logic              done, wr_busy;
    logic [W_LANE-1:0] taps;
    logic [W_WORD-1:0] shifted;
    logic [BW-1:0]     beats_total;

    pspi_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.busy),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    pspi_lane_map #(.W_WORD(W_WORD), .W_LANE(W_LANE)) i_lane_map (
        .mode_i    (st_q.mode),
        .shreg_i   (st_q.shreg),
        .somi_i    (somi_i),
        .taps_o    (taps),
        .shifted_o (shifted)
    );

    pspi_flags i_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .done_i    (done),
        .wr_busy_i (wr_busy),
        .clr_i     (flag_clr_i),
        .rx_int_o  (rx_int_o),
        .rx_ovr_o  (rx_ovr_o),
        .tx_err_o  (tx_err_o)
    );

    always_comb begin
        st_d        = st_q;
        done        = 1'b0;
        wr_busy     = 1'b0;
        beats_total = BW'(W_WORD >> st_q.mode);
        if (!st_q.busy) begin
            if (tx_wr_i) begin
                st_d.busy  = 1'b1;
                st_d.mode  = lane_mode_i;
                st_d.shreg = tx_data_i;
                st_d.beats = '0;
            end
        end else begin
            wr_busy = tx_wr_i;
            if (rise) begin
                st_d.shreg = shifted;
                st_d.beats = st_q.beats + BW'(1);
            end
            if (fall && (st_q.beats == beats_total)) begin
                st_d.busy  = 1'b0;
                st_d.rxbuf = st_q.shreg;
                done       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign cs_n_o    = !st_q.busy;
    assign simo_o    = st_q.busy ? taps : '0;
    assign rx_data_o = st_q.rxbuf;

    // R1/R7: idle means deselected with a parked clock
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> cs_n_o && !sclk_o && (simo_o == '0));

    // R3: captured mode does not move while a word is in flight
    a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) |-> $stable(st_q.mode));

    // R4: lanes above the active count stay low
    a_r4_unused_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ((simo_o >> (1 << st_q.mode)) == '0));

    // R6: never more rising edges than the word needs
    a_r6_beat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.beats <= beats_total);

    // R6: the receive flag rises together with the end of the transfer
    a_r6_int_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_int_o) |-> $fell(busy_o));

    // R8: the word in flight survives a late write
    a_r8_keep_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && tx_wr_i && !rise |=> $stable(st_q.shreg));

endmodule

// File: tb/test_pspi_engine.sv
module test_pspi_engine;
    localparam int unsigned HD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic [1:0]  lane_mode = '0;
    logic        flag_clr = 1'b0;
    logic [7:0]  somi = '0;
    logic        sclk, cs_n, busy, rx_int, rx_ovr, tx_err;
    logic [7:0]  simo;
    logic [15:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    pspi_engine #(.HALF_DIV(HD)) i_pspi_engine (
        .clk_i(clk), .rst_ni(rst_n), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
        .lane_mode_i(lane_mode), .flag_clr_i(flag_clr), .somi_i(somi),
        .sclk_o(sclk), .simo_o(simo), .cs_n_o(cs_n), .busy_o(busy),
        .rx_data_o(rx_data), .rx_int_o(rx_int), .rx_ovr_o(rx_ovr), .tx_err_o(tx_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_taps(logic [15:0] w, int mode, int j);
        int nl = 1 << mode;
        int sw = 16 >> mode;
        logic [7:0] r = '0;
        for (int k = 0; k < nl; k++) r[k] = w[k*sw + sw - 1 - j];
        return r;
    endfunction

    // One full word; optional mid-word mode change, late write, and clear at completion
    task automatic run_word(input logic [15:0] w, input int mode, input bit mess_mode,
                            input bit late_wr, input bit clr_at_end);
        int nl = 1 << mode;
        int sw = 16 >> mode;
        int beats = 16 >> mode;
        logic [15:0] rx_exp = '0;
        int hi;
        @(negedge clk);
        tx_wr = 1'b1; tx_data = w; lane_mode = 2'(mode);
        @(negedge clk);
        tx_wr = 1'b0;
        check(busy && !cs_n && !sclk, "R2", {busy, cs_n, sclk}, 3'b100);
        if (mess_mode) lane_mode = 2'(mode ^ 1);
        for (int j = 0; j < beats; j++) begin
            while (sclk) @(negedge clk);
            check(simo == exp_taps(w, mode, j), "R4", simo, exp_taps(w, mode, j));
            somi = 8'($urandom);
            for (int k = 0; k < nl; k++) rx_exp[k*sw + sw - 1 - j] = somi[k];
            if (late_wr && j == 1) begin
                tx_wr = 1'b1; tx_data = ~w;
                @(negedge clk);
                tx_wr = 1'b0;
            end
            while (!sclk) @(negedge clk);
            hi = 0;
            while (sclk) begin
                hi++;
                if (clr_at_end && j == beats - 1 && hi == HD) flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
            end
            if (j == 0) check(hi == HD, "R7", hi, HD);
        end
        check(!busy && cs_n && !sclk, "R6", {busy, cs_n, sclk}, 3'b010);
        check(rx_data == rx_exp, mess_mode ? "R3" : "R5", rx_data, rx_exp);
        check(rx_int, "R6", rx_int, 1);
        if (late_wr) check(tx_err, "R8", tx_err, 1);
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(cs_n && !sclk && simo == 0 && !busy && rx_data == 0 && !rx_int && !rx_ovr && !tx_err,
              "R1", {cs_n, sclk, busy, rx_int, rx_ovr, tx_err}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: one directed word per lane count
        for (int m = 0; m < 4; m++) begin
            run_word(16'hA53C ^ 16'(m * 16'h1111), m, 1'b0, 1'b0, 1'b0);
            clear_flags();
            check(!rx_int && !rx_ovr && !tx_err, "R10", {rx_int, rx_ovr, tx_err}, 0);
        end

        // R3: mode change while busy ignored
        run_word(16'h8001, 2, 1'b1, 1'b0, 1'b0);
        // R9: second completion without clearing -> overrun
        check(!rx_ovr, "R9", rx_ovr, 0);
        run_word(16'h7FFE, 0, 1'b0, 1'b0, 1'b0);
        check(rx_int && rx_ovr, "R9", {rx_int, rx_ovr}, 2'b11);
        clear_flags();

        // R8: late write ignored, error raised
        run_word(16'hC3A5, 1, 1'b0, 1'b1, 1'b0);
        clear_flags();

        // R10: clear in the completion cycle while rx_int already set
        run_word(16'h1234, 3, 1'b0, 1'b0, 1'b0);
        run_word(16'hFEDC, 3, 1'b0, 1'b0, 1'b1);
        check(rx_int && !rx_ovr, "R10", {rx_int, rx_ovr}, 2'b10);
        clear_flags();

        // Random words over all lane counts
        for (int i = 0; i < 40; i++) begin
            run_word(16'($urandom), int'($urandom % 4), 1'b0, 1'b0, 1'b0);
            if ($urandom % 2) clear_flags();
        end

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule